// File: doc/BRIEF.md
# Multi-Function Power-Series Evaluator

This block computes one of four elementary functions of a signed fixed-point operand: the exponential, the sine, the cosine, or the natural logarithm of one plus the operand. Each function is evaluated by adding six terms of its expansion around zero. A 2-bit selector picks the function. A start pulse captures the operand and the selector. After a fixed number of cycles an 18-bit result appears together with a ready flag.

One sequencer and one shared datapath serve all four functions. The datapath keeps a running power of the operand, a term register and a wide accumulator. The function selector sets four things: the first power (one or the operand), the power step (the operand or its square), the divisor of each term, and whether the signs alternate. The divisor is a factorial or the plain power index, and it is read as a reciprocal from a small constant table, so the block needs no divider. Range reduction is out of scope. The caller keeps the operand inside the interval where the series is meaningful.

Top module: `maclaurin_eval`

## Requirements
- R1: With selector 2'b00 the result is the sum of x^n/n! for n = 0..5, where x is the operand read as signed Q2.14 and the result is signed Q3.15, rounded to nearest, within 2 LSB.
- R2: With selector 2'b01 the result is the sum of (-1)^k·x^(2k+1)/(2k+1)! for k = 0..5, within 2 LSB.
- R3: With selector 2'b10 the result is the sum of (-1)^k·x^(2k)/(2k)! for k = 0..5, within 2 LSB.
- R4: With selector 2'b11 the result is the sum of (-1)^(n+1)·x^n/n for n = 1..6, within 2 LSB.
- R5: A sum above the Q3.15 range gives 131071 (18'h1FFFF). A sum below it gives -131072 (18'h20000).
- R6: `ready` is low while a computation runs. It rises exactly 18 clock edges after the edge that accepts `start`.
- R7: Once `ready` is high, `ready` and `result` keep their values until the next `start` is accepted.
- R8: The block accepts `start` only when it is idle or finished, and at that edge it captures `func` and `operand`. A `start` during a computation, or a change on `func` or `operand`, neither alters the result nor produces an extra result.
- R9: While `rst_n` is low at a clock edge, the block returns to idle with `ready` low and `result` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a computation; accepted when idle or finished |
| func | input | 2 | Function select: 00 exp, 01 sin, 10 cos, 11 ln(1+x) |
| operand | input | 16 | Signed Q2.14 argument |
| result | output | 18 | Signed Q3.15 series sum, saturated |
| ready | output | 1 | Result valid; held until the next accepted start |

## Verification
The hold and stability properties apply only while `start` is low, and the latency property counts from an accepted `start`. The stimulus therefore drives `start` as a one-cycle pulse and waits for `ready` before it sends the next request, except for one deliberate pulse sent during a computation. The 2 LSB tolerance relies on coefficient truncation staying well below one result LSB. For that reason the sine and logarithm series are given operands of magnitude at most one, and the larger operands go to the exponential, the cosine and the logarithm's saturation case, whose high-order terms stay small.

// File: rtl/mser_pkg.sv
// Shared types and constant helpers for the power-series evaluator.
// Assumes: the factorial helper is used only for indices up to 20.
package mser_pkg;

    // Function selector encoding; the value is visible at the port.
    typedef enum logic [1:0] {
        FN_EXP  = 2'b00,
        FN_SIN  = 2'b01,
        FN_COS  = 2'b10,
        FN_LN1P = 2'b11
    } fn_sel_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_INIT     = 3'd1,
        ST_MUL_POW  = 3'd2,
        ST_MUL_COEF = 3'd3,
        ST_ACCUM    = 3'd4,
        ST_DONE     = 3'd5
    } ctl_st_e;

    // n! evaluated at elaboration time for the reciprocal table.
    function automatic longint unsigned fact_f(input int n);
        longint unsigned f;
        f = 64'd1;
        for (int i = 2; i <= n; i++) begin
            f = f * longint'(i);
        end
        return f;
    endfunction

endpackage

// File: rtl/mser_coef_rom.sv
// Reciprocal table: for a power index it returns 1/n! or 1/n as an
// unsigned value with FR fraction bits, sign-extended to W bits.
// Assumes: MAXP <= 20 so that the factorials fit in 64 bits; an index
// above MAXP returns zero.
module mser_coef_rom #(
    parameter int MAXP = 11,
    parameter int IW   = 4,
    parameter int W    = 48,
    parameter int FR   = 24
) (
    input  logic [IW-1:0]       idx,
    input  logic                recip_n,
    output logic signed [W-1:0] coef
);
    localparam logic [IW-1:0] LAST = IW'(MAXP);

    logic signed [W-1:0] fact_tab [0:MAXP];
    logic signed [W-1:0] lin_tab  [0:MAXP];

    // One table row per power index, both divisor kinds.
    for (genvar g = 0; g <= MAXP; g++) begin : g_row
        localparam longint unsigned FV = (64'd1 << FR) / mser_pkg::fact_f(g);
        localparam longint unsigned LV = (64'd1 << FR) / longint'((g == 0) ? 1 : g);
        assign fact_tab[g] = W'(FV);
        assign lin_tab[g]  = W'(LV);
    end

    // Pick the divisor kind and guard the index range.
    always_comb begin
        coef = '0;
        if (idx <= LAST) begin
            coef = recip_n ? lin_tab[idx] : fact_tab[idx];
        end
    end

endmodule

// File: rtl/mser_ctrl.sv
// Sequencer: accepts a start when idle or finished and then walks the
// terms. The first term is loaded, and each later term needs one power
// step; every term is scaled by its coefficient and then accumulated.
// Assumes: NTERMS >= 1; the datapath obeys the enables it is given.
module mser_ctrl
    import mser_pkg::*;
#(
    parameter int NTERMS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic load_en,
    output logic pow_en,
    output logic coef_en,
    output logic acc_en,
    output logic odd_term,
    output logic last_term,
    output logic ready
);
    localparam int KW = (NTERMS > 1) ? $clog2(NTERMS) : 1;
    localparam logic [KW-1:0] K_LAST = KW'(NTERMS - 1);

    ctl_st_e       state_q, state_d;
    logic [KW-1:0] k_q;
    logic          busy;

    assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign accept    = start && !busy;
    assign load_en   = (state_q == ST_INIT);
    assign pow_en    = (state_q == ST_MUL_POW);
    assign coef_en   = (state_q == ST_MUL_COEF);
    assign acc_en    = (state_q == ST_ACCUM);
    assign odd_term  = k_q[0];
    assign last_term = (k_q == K_LAST);
    assign ready     = (state_q == ST_DONE);

    // Next-state choice for the term walk.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (start) state_d = ST_INIT;
            ST_INIT:     state_d = ST_MUL_COEF;
            ST_MUL_POW:  state_d = ST_MUL_COEF;
            ST_MUL_COEF: state_d = ST_ACCUM;
            ST_ACCUM:    state_d = last_term ? ST_DONE : ST_MUL_POW;
            ST_DONE:     if (start) state_d = ST_INIT;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Term counter: cleared on load, advanced after each accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n)       k_q <= '0;
        else if (load_en) k_q <= '0;
        else if (acc_en)  k_q <= k_q + KW'(1);
    end

    // R8: a start that arrives mid-computation never restarts the walk.
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state_q != ST_INIT));

    // R7: the finished state persists until a start arrives.
    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DONE) && !start) |=> (state_q == ST_DONE));

endmodule

// File: rtl/mser_datapath.sv
// Shared arithmetic: the captured operand, its square, the running power,
// the current term, the accumulator and the saturated, rounded result.
// Assumes: 2*XF >= FR >= XF and FR > RF; W leaves enough integer bits for
// the powers that the caller allows (|x| <= 2 gives at most 2^11).
module mser_datapath
    import mser_pkg::*;
#(
    parameter int XW     = 16,
    parameter int XF     = 14,
    parameter int RW     = 18,
    parameter int RF     = 15,
    parameter int W      = 48,
    parameter int FR     = 24,
    parameter int IW     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic                load_en,
    input  logic                pow_en,
    input  logic                coef_en,
    input  logic                acc_en,
    input  logic                odd_term,
    input  logic                last_term,
    input  logic [1:0]          func,
    input  logic [XW-1:0]       operand,
    input  logic signed [W-1:0] coef,
    output logic [IW-1:0]       idx,
    output logic                recip_n,
    output logic [RW-1:0]       result
);
    localparam int XSH = FR - XF;
    localparam int SQSH = 2 * XF - FR;
    localparam int RSH = FR - RF;
    localparam logic signed [W-1:0] ONE_FX = W'(1) <<< FR;
    localparam logic signed [W-1:0] HALF_LSB = W'(1) <<< (RSH - 1);
    localparam logic signed [W-1:0] RMAX = (W'(1) <<< (RW - 1)) - W'(1);
    localparam logic signed [W-1:0] RMIN = -(W'(1) <<< (RW - 1));

    logic signed [XW-1:0]   x_q;
    fn_sel_e                fn_q;
    logic signed [W-1:0]    step_q, pow_q, term_q, acc_q;
    logic [IW-1:0]          idx_q;
    logic [RW-1:0]          res_q;

    logic signed [W-1:0]    x_fx, xsq_fx, acc_nxt, rnd, scaled, clipped;
    logic signed [2*XW-1:0] xsq;
    logic signed [2*W-1:0]  pow_prod, term_prod;
    logic                   stride2, neg_term;

    assign idx     = idx_q;
    assign recip_n = (fn_q == FN_LN1P);
    assign result  = res_q;
    assign stride2 = (fn_q == FN_SIN) || (fn_q == FN_COS);
    assign neg_term = (fn_q != FN_EXP) && odd_term;

    // Operand and its square rescaled to the internal fraction width.
    always_comb begin
        x_fx   = W'(x_q) <<< XSH;
        xsq    = x_q * x_q;
        xsq_fx = W'(xsq) >>> SQSH;
    end

    // Full-width products for the power step and the coefficient scaling.
    always_comb begin
        pow_prod  = pow_q * step_q;
        term_prod = pow_q * coef;
    end

    // Signed accumulation followed by rounding and saturation.
    always_comb begin
        acc_nxt = neg_term ? (acc_q - term_q) : (acc_q + term_q);
        rnd     = acc_nxt + HALF_LSB;
        scaled  = rnd >>> RSH;
        if (scaled > RMAX)      clipped = RMAX;
        else if (scaled < RMIN) clipped = RMIN;
        else                    clipped = scaled;
    end

    // Capture the request when the sequencer accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            fn_q <= FN_EXP;
        end else if (cap_en) begin
            x_q  <= operand;
            fn_q <= fn_sel_e'(func);
        end
    end

    // Power, step and power index: seeded per function, then stepped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pow_q  <= '0;
            step_q <= '0;
            idx_q  <= '0;
        end else if (load_en) begin
            step_q <= stride2 ? xsq_fx : x_fx;
            if ((fn_q == FN_EXP) || (fn_q == FN_COS)) begin
                pow_q <= ONE_FX;
                idx_q <= '0;
            end else begin
                pow_q <= x_fx;
                idx_q <= IW'(1);
            end
        end else if (pow_en) begin
            pow_q <= W'(pow_prod >>> FR);
            idx_q <= idx_q + (stride2 ? IW'(2) : IW'(1));
        end
    end

    // Term register: power scaled by the table reciprocal.
    always_ff @(posedge clk) begin
        if (!rst_n)       term_q <= '0;
        else if (coef_en) term_q <= W'(term_prod >>> FR);
    end

    // Accumulator: cleared on load, summed once per term.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (load_en) acc_q <= '0;
        else if (acc_en)  acc_q <= acc_nxt;
    end

    // Result register: written only by the last accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n)                    res_q <= '0;
        else if (acc_en && last_term)  res_q <= RW'(clipped);
    end

    // R8: the captured request is frozen between accepts.
    p_capture_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(x_q) && $stable(fn_q)));

endmodule

// File: rtl/maclaurin_eval.sv
// Top level: sequencer, shared datapath and reciprocal table.
// Assumes: start is synchronous to clk; the operand is within the range
// where the chosen series converges (not checked by the block).
module maclaurin_eval #(
    parameter int XW     = 16,
    parameter int XF     = 14,
    parameter int RW     = 18,
    parameter int RF     = 15,
    parameter int NTERMS = 6,
    parameter int W      = 48,
    parameter int FR     = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    func,
    input  logic [XW-1:0] operand,
    output logic [RW-1:0] result,
    output logic          ready
);
    localparam int MAXP = 2 * NTERMS - 1;
    localparam int IW   = $clog2(MAXP + 1);
    localparam int LAT  = 3 * NTERMS;
    localparam int LCW  = $clog2(LAT + 2) + 1;

    logic                accept, load_en, pow_en, coef_en, acc_en;
    logic                odd_term, last_term, recip_n;
    logic [IW-1:0]       idx;
    logic signed [W-1:0] coef;

    mser_ctrl #(.NTERMS(NTERMS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .accept    (accept),
        .load_en   (load_en),
        .pow_en    (pow_en),
        .coef_en   (coef_en),
        .acc_en    (acc_en),
        .odd_term  (odd_term),
        .last_term (last_term),
        .ready     (ready)
    );

    mser_datapath #(
        .XW(XW), .XF(XF), .RW(RW), .RF(RF), .W(W), .FR(FR), .IW(IW)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (accept),
        .load_en   (load_en),
        .pow_en    (pow_en),
        .coef_en   (coef_en),
        .acc_en    (acc_en),
        .odd_term  (odd_term),
        .last_term (last_term),
        .func      (func),
        .operand   (operand),
        .coef      (coef),
        .idx       (idx),
        .recip_n   (recip_n),
        .result    (result)
    );

    mser_coef_rom #(.MAXP(MAXP), .IW(IW), .W(W), .FR(FR)) u_rom (
        .idx     (idx),
        .recip_n (recip_n),
        .coef    (coef)
    );

    // Cycles since the accepting edge, used only by the latency check.
    logic [LCW-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                       lat_cnt <= '0;
        else if (accept)                  lat_cnt <= LCW'(1);
        else if (!ready && lat_cnt != '0) lat_cnt <= lat_cnt + LCW'(1);
    end

    // R6: ready rises a fixed number of edges after acceptance.
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (lat_cnt == LCW'(LAT + 1)));

    // R7: a finished result stays put until the next start.
    p_result_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> $stable(result));

    // R9: reset clears the visible state.
    p_reset_state_r9: assert property (@(posedge clk)
        !rst_n |=> (!ready && (result == '0)));

endmodule

// File: tb/sim_maclaurin_eval.sv
`timescale 1ns/1ps
module sim_maclaurin_eval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  func = 2'b00;
    logic [15:0] operand = '0;
    logic [17:0] result;
    logic        ready;

    int     total = 0;
    int     bad = 0;
    longint cyc = 0;
    bit     finished = 1'b0;

    typedef struct {
        int     expv;
        string  req;
        longint t0;
    } exp_t;
    exp_t sbq[$];

    maclaurin_eval u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .func    (func),
        .operand (operand),
        .result  (result),
        .ready   (ready)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
        end
    endtask

    // Six-term series in real arithmetic, straight from the requirements.
    function automatic real ref_series(input int fsel, input real x);
        real sum = 0.0;
        for (int k = 0; k < 6; k++) begin
            int  n;
            real p = 1.0;
            real d = 1.0;
            case (fsel)
                0: n = k;
                1: n = 2 * k + 1;
                2: n = 2 * k;
                default: n = k + 1;
            endcase
            for (int i = 0; i < n; i++) p = p * x;
            if (fsel == 3) d = real'(n);
            else for (int i = 2; i <= n; i++) d = d * real'(i);
            if (fsel != 0 && (k % 2) == 1) sum = sum - p / d;
            else                           sum = sum + p / d;
        end
        return sum;
    endfunction

    function automatic int expect_code(input real v);
        real r = $floor(v * 32768.0 + 0.5);
        if (r > 131071.0)  r = 131071.0;
        if (r < -131072.0) r = -131072.0;
        return $rtoi(r);
    endfunction

    // Driver: queue the expectation, pulse start, optionally disturb.
    task automatic run_case(input int fsel, input int xc, input string req,
                            input bit scramble);
        exp_t it;
        @(negedge clk);
        it.expv = expect_code(ref_series(fsel, $itor(xc) / 16384.0));
        it.req  = req;
        it.t0   = cyc;
        sbq.push_back(it);
        func    = 2'(fsel);
        operand = 16'(xc);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ready == 1'b0, "R6", "ready low while computing", ready, 0);
        if (scramble) begin
            repeat (3) @(negedge clk);
            func    = ~func;
            operand = ~operand;
            start   = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!ready) @(negedge clk);
    endtask

    // Monitor: on each new result, pop and compare value and latency.
    logic rdy_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && ready && !rdy_prev) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R8", "unexpected extra result", $signed(result), 0);
            end else begin
                exp_t it;
                int   act;
                int   diff;
                it   = sbq.pop_front();
                act  = int'($signed(result));
                diff = act - it.expv;
                if (diff < 0) diff = -diff;
                chk(diff <= 2, it.req, "result value", act, it.expv);
                chk((cyc - it.t0) == 19, "R6", "latency", cyc - it.t0, 19);
            end
        end
        rdy_prev = ready;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ready == 1'b0, "R9", "ready in reset", ready, 0);
        chk(result == '0, "R9", "result in reset", result, 0);
        rst_n = 1'b1;

        // R1 exponential
        run_case(0, 0,      "R1", 1'b0);
        run_case(0, 4096,   "R1", 1'b0);
        run_case(0, 8192,   "R1", 1'b0);
        run_case(0, -8192,  "R1", 1'b0);
        run_case(0, 16384,  "R1", 1'b0);
        run_case(0, -16384, "R1", 1'b0);
        // R2 sine
        run_case(1, 0,      "R2", 1'b0);
        run_case(1, 4096,   "R2", 1'b0);
        run_case(1, 8192,   "R2", 1'b0);
        run_case(1, -8192,  "R2", 1'b0);
        run_case(1, 16384,  "R2", 1'b0);
        // R3 cosine
        run_case(2, 0,      "R3", 1'b0);
        run_case(2, 4096,   "R3", 1'b0);
        run_case(2, 8192,   "R3", 1'b0);
        run_case(2, -24576, "R3", 1'b0);
        // R4 logarithm of one plus x
        run_case(3, 0,      "R4", 1'b0);
        run_case(3, 4096,   "R4", 1'b0);
        run_case(3, 8192,   "R4", 1'b0);
        run_case(3, 16384,  "R4", 1'b0);
        run_case(3, -16220, "R4", 1'b0);
        // R5 saturation at both ends
        run_case(0, 32604,  "R5", 1'b0);
        chk(result == 18'h1FFFF, "R5", "positive clamp", result, 18'h1FFFF);
        run_case(3, -32768, "R5", 1'b0);
        chk(result == 18'h20000, "R5", "negative clamp", result, 18'h20000);

        // R8 disturbance during a computation
        run_case(0, 8192, "R8", 1'b1);

        // R7 hold after completion
        begin
            logic [17:0] held;
            held = result;
            repeat (6) @(negedge clk);
            chk(ready == 1'b1, "R7", "ready held", ready, 1);
            chk(result == held, "R7", "result held", result, held);
        end

        // R9 reset after a result clears it
        rst_n = 1'b0;
        @(negedge clk);
        chk(ready == 1'b0, "R9", "ready after reset", ready, 0);
        chk(result == '0, "R9", "result after reset", result, 0);
        rst_n = 1'b1;
        run_case(2, 4096, "R3", 1'b0);

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R8", "pending expectations", sbq.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5ns * 20000);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "R6", "watchdog expired", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule